// File: doc/BRIEF.md
# DDR Burst Write Capture Path

This block is the device-side write path of a double-data-rate memory. A write request carries a start column and a burst-length code. After the request the block takes one data beat and one mask bit on each rising edge and on each falling edge of the write strobe. It joins every rise/fall pair of beats into one double-width core word. That word goes out with a two-bit byte enable and the column of its first beat, so a behavioural storage array can commit it in a single clock.

The strobe runs free at the core rate and is the block's only clock. A request is taken on a rising edge when no burst is running. The first rise beat is taken one rising edge later and its partner on the next falling edge. A complete word appears on the core outputs one rising edge after that. Each burst produces half as many core words as it has beats, one per clock and with no gaps. Column addresses wrap inside the aligned block whose size is the burst length.

Top module: `ddrw_capture`

## Requirements
- R1: The low half of `core_data` holds the beat sampled on a rising strobe edge, and the high half holds the beat sampled on the falling edge that follows it.
- R2: A beat whose `dm_in` was sampled high is not written. `core_be` bit 0 is the inverse of the rise-beat mask and bit 1 is the inverse of the fall-beat mask.
- R3: For a request sampled at rising edge P0, the rise beat of pair k is taken at edge P(k+1). Word k is then valid on the outputs from edge P(k+2), with `core_we` high for one cycle per word and on consecutive cycles.
- R4: `wr_len` selects the burst length: 00 gives 2 beats, 01 gives 4 beats, and 10 or 11 give 8 beats. A burst emits exactly length/2 words.
- R5: With beat count L and start column S (11 bits), word k carries column (S with its low log2(L) bits cleared) OR ((S + 2k) mod L).
- R6: A request sampled while `busy` is high is ignored: the running burst's data and columns are unchanged. For that edge only, `overlap_err` is high for one cycle.
- R7: `busy` rises on the edge that accepts a request and falls on the edge that takes the last rise beat. When no word is being emitted, `core_we` is low and `core_be` is zero.
- R8: A synchronous active-high `rst` clears `busy`, `core_we`, `core_be` and `overlap_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe | input | 1 | Write strobe; both edges sample data, rising edge samples commands |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_col | input | 11 | Start column of the burst |
| wr_len | input | 2 | Burst-length code |
| dq_in | input | 4 | Data beat |
| dm_in | input | 1 | Mask for the current beat, high means do not write |
| core_we | output | 1 | Core word valid |
| core_col | output | 11 | Column of the first beat of the word |
| core_data | output | 8 | Fall beat in the high half, rise beat in the low half |
| core_be | output | 2 | Per-beat write enable |
| busy | output | 1 | Burst in progress |
| overlap_err | output | 1 | Pulse when a request was ignored |

## Verification
The sweep covers every length code and all eight low start-column values, each with distinct beat values and a different per-beat mask pattern. Wrong wrap arithmetic, a swapped rise/fall half, a swapped enable bit, or a wrong word count then each give a different mismatch. One eight-beat burst is interrupted by a second request that has a different column and length. This shows whether the running burst is really left untouched and whether the error pulse lands on the right cycle. Looking at the outputs one edge after each burst ends shows whether the burst stops cleanly.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

    typedef enum logic [1:0] {
        LEN_TWO    = 2'b00,
        LEN_FOUR   = 2'b01,
        LEN_EIGHT  = 2'b10,
        LEN_EIGHTX = 2'b11
    } len_code_e;

    function automatic logic [3:0] beats_of(input logic [1:0] code);
        case (len_code_e'(code))
            LEN_TWO:  return 4'd2;
            LEN_FOUR: return 4'd4;
            default:  return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/ddrw_burst_seq.sv
module ddrw_burst_seq #(
    parameter int COL_W  = 11,
    parameter int MAX_BL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_code,
    output logic             busy,
    output logic [COL_W-1:0] cur_col,
    output logic             overlap
);
    import ddrw_pkg::*;

    localparam int OFF_W = $clog2(MAX_BL);
    localparam int CNT_W = OFF_W + 1;

    logic [CNT_W-1:0] pairs_left;
    logic [CNT_W-1:0] blen;
    logic [OFF_W-1:0] offset;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] low_mask;

    always_comb begin
        low_mask = COL_W'(blen) - COL_W'(1);
        cur_col  = (base & ~low_mask) | ((base + COL_W'(offset)) & low_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            pairs_left <= '0;
            blen       <= CNT_W'(2);
            offset     <= '0;
            base       <= '0;
            overlap    <= 1'b0;
        end else begin
            overlap <= req && busy;
            if (busy) begin
                offset     <= offset + OFF_W'(2);
                pairs_left <= pairs_left - CNT_W'(1);
                if (pairs_left == CNT_W'(1))
                    busy <= 1'b0;
            end else if (req) begin
                busy       <= 1'b1;
                base       <= start_col;
                blen       <= CNT_W'(beats_of(len_code));
                pairs_left <= CNT_W'(beats_of(len_code) >> 1);
                offset     <= '0;
            end
        end
    end

endmodule

// File: rtl/ddrw_beat_pair.sv
module ddrw_beat_pair #(
    parameter int DQ_W  = 4,
    parameter int COL_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [COL_W-1:0]  col_in,
    input  logic [DQ_W-1:0]   dq,
    input  logic              dm,
    output logic              word_vld,
    output logic [COL_W-1:0]  word_col,
    output logic [2*DQ_W-1:0] word_data,
    output logic [1:0]        word_be
);
    typedef struct packed {
        logic [DQ_W-1:0] data;
        logic            mask;
    } beat_t;

    beat_t            rise_q;
    beat_t            fall_q;
    logic             pending;
    logic [COL_W-1:0] pend_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            rise_q   <= '0;
            pend_col <= '0;
        end else begin
            pending <= take;
            if (take) begin
                rise_q   <= '{data: dq, mask: dm};
                pend_col <= col_in;
            end
        end
    end

    always_ff @(negedge clk) begin
        if (rst)
            fall_q <= '0;
        else if (pending)
            fall_q <= '{data: dq, mask: dm};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_vld  <= 1'b0;
            word_col  <= '0;
            word_data <= '0;
            word_be   <= '0;
        end else begin
            word_vld <= pending;
            if (pending) begin
                word_col  <= pend_col;
                word_data <= {fall_q.data, rise_q.data};
                word_be   <= ~{fall_q.mask, rise_q.mask};
            end else begin
                word_be   <= '0;
            end
        end
    end

endmodule

// File: rtl/ddrw_capture.sv
module ddrw_capture #(
    parameter int DQ_W   = 4,
    parameter int COL_W  = 11,
    parameter int MAX_BL = 8
) (
    input  logic              strobe,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [1:0]        wr_len,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic              dm_in,
    output logic              core_we,
    output logic [COL_W-1:0]  core_col,
    output logic [2*DQ_W-1:0] core_data,
    output logic [1:0]        core_be,
    output logic              busy,
    output logic              overlap_err
);
    logic [COL_W-1:0] seq_col;

    ddrw_burst_seq #(.COL_W(COL_W), .MAX_BL(MAX_BL)) seq_i (
        .clk       (strobe),
        .rst       (rst),
        .req       (wr_req),
        .start_col (wr_col),
        .len_code  (wr_len),
        .busy      (busy),
        .cur_col   (seq_col),
        .overlap   (overlap_err)
    );

    ddrw_beat_pair #(.DQ_W(DQ_W), .COL_W(COL_W)) pair_i (
        .clk       (strobe),
        .rst       (rst),
        .take      (busy),
        .col_in    (seq_col),
        .dq        (dq_in),
        .dm        (dm_in),
        .word_vld  (core_we),
        .word_col  (core_col),
        .word_data (core_data),
        .word_be   (core_be)
    );

endmodule

// File: rtl/ddrw_capture_chk.sv
module ddrw_capture_chk #(
    parameter int MAX_BL = 8
) (
    input logic       strobe,
    input logic       rst,
    input logic       wr_req,
    input logic       busy,
    input logic       overlap_err,
    input logic       core_we,
    input logic [1:0] core_be
);
    logic [7:0] busy_run;

    always_ff @(posedge strobe) begin
        if (rst)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 8'd1;
        else
            busy_run <= '0;
    end

    // R7
    be_idle_chk: assert property (@(posedge strobe) disable iff (rst)
        !core_we |-> core_be == 2'b00);

    // R4
    busy_len_chk: assert property (@(posedge strobe) disable iff (rst)
        busy_run <= 8'(MAX_BL / 2));

    // R6
    err_cause_chk: assert property (@(posedge strobe) disable iff (rst)
        overlap_err |-> $past(wr_req && busy));

    // R7
    accept_chk: assert property (@(posedge strobe) disable iff (rst)
        (wr_req && !busy) |=> busy);

    // R3
    we_src_chk: assert property (@(posedge strobe) disable iff (rst)
        core_we |-> $past(busy, 2));

endmodule

bind ddrw_capture ddrw_capture_chk #(.MAX_BL(MAX_BL)) chk_i (
    .strobe      (strobe),
    .rst         (rst),
    .wr_req      (wr_req),
    .busy        (busy),
    .overlap_err (overlap_err),
    .core_we     (core_we),
    .core_be     (core_be)
);

// File: tb/ddrw_capture_tb.sv
module ddrw_capture_tb_top;

    logic        strobe = 1'b0;
    logic        rst;
    logic        wr_req;
    logic [10:0] wr_col;
    logic [1:0]  wr_len;
    logic [3:0]  dq_in;
    logic        dm_in;
    logic        core_we;
    logic [10:0] core_col;
    logic [7:0]  core_data;
    logic [1:0]  core_be;
    logic        busy;
    logic        overlap_err;

    int checks = 0;
    int errors = 0;

    always #10 strobe = ~strobe;

    ddrw_capture dut_i (
        .strobe      (strobe),
        .rst         (rst),
        .wr_req      (wr_req),
        .wr_col      (wr_col),
        .wr_len      (wr_len),
        .dq_in       (dq_in),
        .dm_in       (dm_in),
        .core_we     (core_we),
        .core_col    (core_col),
        .core_data   (core_data),
        .core_be     (core_be),
        .busy        (busy),
        .overlap_err (overlap_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] beat_val(input int seed, input int i);
        return 4'(seed * 5 + i * 3 + 1);
    endfunction

    task automatic run_burst(input logic [1:0] code, input logic [10:0] st,
                             input int seed, input logic [7:0] mp, input bit poke);
        int nb;
        int np;
        logic [10:0] lm;
        nb = (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 8;
        np = nb / 2;
        lm = 11'(nb - 1);
        @(negedge strobe);
        #5;
        wr_req = 1'b1;
        wr_col = st;
        wr_len = code;
        @(posedge strobe);
        fork
            begin
                #5;
                wr_req = 1'b0;
                for (int k = 0; k < np; k++) begin
                    @(negedge strobe);
                    #5;
                    dq_in = beat_val(seed, 2 * k);
                    dm_in = mp[2 * k];
                    if (poke && k == 1) begin
                        wr_req = 1'b1;
                        wr_col = ~st;
                        wr_len = 2'b00;
                    end
                    @(posedge strobe);
                    #5;
                    wr_req = 1'b0;
                    dq_in = beat_val(seed, 2 * k + 1);
                    dm_in = mp[2 * k + 1];
                end
            end
            begin
                @(posedge strobe);
                for (int k = 0; k < np; k++) begin
                    logic [10:0] ecol;
                    logic [7:0]  edata;
                    logic [1:0]  ebe;
                    @(posedge strobe);
                    #2;
                    ecol  = (st & ~lm) | ((st + 11'(2 * k)) & lm);
                    edata = {beat_val(seed, 2 * k + 1), beat_val(seed, 2 * k)};
                    ebe   = ~{mp[2 * k + 1], mp[2 * k]};
                    chk(core_we == 1'b1, "R3 core_we per word", int'(core_we), 1);
                    chk(core_data == edata, "R1 word halves", int'(core_data), int'(edata));
                    chk(core_be == ebe, "R2 byte enable from masks", int'(core_be), int'(ebe));
                    chk(core_col == ecol, "R5 column wrap", int'(core_col), int'(ecol));
                    if (k == 0)
                        chk(overlap_err == poke, "R6 overlap pulse", int'(overlap_err), int'(poke));
                    if (k == 1 && poke)
                        chk(overlap_err == 1'b0, "R6 pulse lasts one cycle", int'(overlap_err), 0);
                end
                @(posedge strobe);
                #2;
                chk(core_we == 1'b0, "R4 word count ends", int'(core_we), 0);
                chk(core_be == 2'b00, "R7 idle enables", int'(core_be), 0);
                chk(busy == 1'b0, "R7 busy falls", int'(busy), 0);
            end
        join
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        wr_req = 1'b0;
        wr_col = '0;
        wr_len = '0;
        dq_in  = '0;
        dm_in  = 1'b0;
        repeat (3) @(posedge strobe);
        #2;
        chk(busy == 1'b0, "R8 reset busy", int'(busy), 0);
        chk(core_we == 1'b0, "R8 reset core_we", int'(core_we), 0);
        chk(core_be == 2'b00, "R8 reset core_be", int'(core_be), 0);
        chk(overlap_err == 1'b0, "R8 reset overlap_err", int'(overlap_err), 0);
        @(negedge strobe);
        rst = 1'b0;

        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
                logic [10:0] st;
                st = (11'(c * 37 + s * 113) & ~11'd7) | 11'(s);
                run_burst(2'(c), st, s + c * 8, 8'(s * 29 + c * 11 + 3), 1'b0);
            end
        end

        run_burst(2'b10, 11'h5fd, 21, 8'h5a, 1'b1);
        run_burst(2'b11, 11'h002, 9, 8'hc3, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule